// File: doc/BRIEF.md
# Serial Control Receiver for an Eight-Register Audio Settings Map

This block is a write-only two-wire (I2C) slave that lets a host load the eight 8-bit settings of an audio preamplifier: volume with loudness, four per-output fader attenuators (front right, front left, rear right, rear left), bass, treble and a switch register. The clock and data lines are sampled with a faster system clock. The block finds START and STOP conditions and compares the first byte with a fixed device address. It then takes a subaddress byte and writes every following byte into the register the subaddress points at. The subaddress steps by one after each data byte.

The eight registers are presented together on one flat output bus. Each committed byte also appears as a one-cycle write pulse that carries the register index and the value. The two-wire bus cannot be held off, because clock stretching is not provided. For that reason the write pulse is valid-only: it has no ready input, any downstream consumer must accept it in the cycle it is shown, and there is no back-pressure. The acknowledge output is an open-drain enable: when it is 1, the pad pulls SDA low.

Top module: `i2c_regmap_slave`

## Requirements
- R1: While reset is low and on release, every register reads 0 except the switch register (index 7), whose general-mute bit (bit 3) reads 1; `sda_pull` and `wr_valid` are 0.
- R2: An address byte equal to 0x80 (seven address bits 1000000 with the write bit 0) is acknowledged by `sda_pull` = 1 during the ninth SCL clock.
- R3: Any other address byte, including 0x81 (a read), is not acknowledged. The block then acknowledges nothing and writes nothing until the next START.
- R4: The byte after an accepted address is acknowledged and taken as the subaddress. Only its bits [2:0] are used; bits [7:3] are ignored.
- R5: Each data byte is acknowledged. The block raises `wr_valid` for exactly one cycle, together with `sda_pull`, at the SCL falling edge that ends the eighth bit. At the same time `wr_idx` carries the current subaddress and `wr_data` carries the byte, MSB first on the wire.
- R6: After each data byte the subaddress increases by one, and it wraps from 7 to 0.
- R7: A repeated START, with no STOP in between, returns the block to address reception, so the next byte is treated as an address.
- R8: After a STOP the block is idle. Bytes clocked without a new START are neither acknowledged nor written.
- R9: Register `i` occupies `regs_flat[8*i+7:8*i]`. It takes the value of `wr_data` in the cycle after a `wr_valid` pulse with `wr_idx` = i. Otherwise the registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples SCL and SDA |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Two-wire bus clock line |
| sda_i | input | 1 | Two-wire bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| wr_valid | output | 1 | One-cycle write pulse, valid-only, no back-pressure |
| wr_idx | output | 3 | Register index of the write |
| wr_data | output | 8 | Byte written |
| regs_flat | output | 64 | All eight registers, index i at bits 8i+7..8i |

## Verification
Each change on SCL passes through two synchronizer flops and one edge-detect stage. The acknowledge and the write pulse therefore appear on the third clock edge after the SCL falling edge that ends the eighth bit, and the register copy follows one cycle after the pulse. The bench holds every SCL half-period for sixteen clocks and reads the acknowledge in the middle of the ninth high phase, well after it is due. A monitor logs each write pulse on the falling clock edge and compares the register slice on the next falling edge. The sweeps start a nine-byte burst from each of the eight subaddresses, so every register and the 7-to-0 wrap are covered, and every expected value is computed from a byte formula.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } rx_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c,
  output logic sda_bit
);
  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s, sda_s;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[SYNC_N-1];
  assign sda_s = sda_sh[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign sda_bit  = sda_s;
endmodule

// File: rtl/i2cr_frame_rx.sv
module i2cr_frame_rx
  import i2cr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h80,
  parameter int         IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             sda_bit,
  output logic             ack_oe,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam int          CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_t          st;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   nbits;
  logic               in_ack;
  logic [IDX_W-1:0]   ptr;
  logic               listening;

  assign listening = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      nbits    <= '0;
      in_ack   <= 1'b0;
      ptr      <= '0;
      ack_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        nbits  <= '0;
        in_ack <= 1'b0;
        ack_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        nbits  <= '0;
        in_ack <= 1'b0;
        ack_oe <= 1'b0;
      end else if (listening) begin
        if (scl_rise && !in_ack && nbits != FULL) begin
          shreg <= {shreg[BYTE_W-2:0], sda_bit};
          nbits <= nbits + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            ack_oe <= 1'b0;
            nbits  <= '0;
          end else if (nbits == FULL) begin
            in_ack <= 1'b1;
            unique case (st)
              ST_ADDR: begin
                if (shreg == DEV_ADDR) begin
                  ack_oe <= 1'b1;
                  st     <= ST_SUB;
                end else begin
                  st <= ST_SKIP;
                end
              end
              ST_SUB: begin
                ack_oe <= 1'b1;
                ptr    <= shreg[IDX_W-1:0];
                st     <= ST_DATA;
              end
              ST_DATA: begin
                ack_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_idx   <= ptr;
                wr_data  <= shreg;
                ptr      <= ptr + 1'b1;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank #(
  parameter int IDX_W    = 3,
  parameter int MUTE_BIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [7:0]                wr_data,
  output logic [(1<<IDX_W)*8-1:0]   regs_flat
);
  localparam int NREG = 1 << IDX_W;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] RST_V = (g == NREG - 1) ? (8'(1) << MUTE_BIT) : 8'h00;
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r <= RST_V;
        else if (wr_valid && wr_idx == IDX_W'(g))
          r <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = r;
    end
  endgenerate
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
  parameter logic [7:0] DEV_ADDR = 8'h80,
  parameter int         IDX_W    = 3,
  parameter int         MUTE_BIT = 3,
  parameter int         SYNC_N   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_pull,
  output logic                    wr_valid,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [7:0]              wr_data,
  output logic [(1<<IDX_W)*8-1:0] regs_flat
);
  logic scl_rise, scl_fall, start_c, stop_c, sda_bit;

  i2cr_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .sda_bit  (sda_bit)
  );

  i2cr_frame_rx #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .sda_bit  (sda_bit),
    .ack_oe   (sda_pull),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  i2cr_regbank #(.IDX_W(IDX_W), .MUTE_BIT(MUTE_BIT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (regs_flat)
  );
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker #(
  parameter int IDX_W    = 3,
  parameter int MUTE_BIT = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_i,
  input logic                    sda_pull,
  input logic                    wr_valid,
  input logic [IDX_W-1:0]        wr_idx,
  input logic [7:0]              wr_data,
  input logic [(1<<IDX_W)*8-1:0] regs_flat
);
  localparam int NREG = 1 << IDX_W;
  localparam logic [NREG*8-1:0] RST_IMG = (NREG*8)'(8'(1) << MUTE_BIT) << ((NREG - 1) * 8);

  logic             pend;
  logic [IDX_W-1:0] l_idx;
  logic [7:0]       l_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      l_idx <= '0;
      l_dat <= '0;
    end else begin
      pend <= wr_valid;
      if (wr_valid) begin
        l_idx <= wr_idx;
        l_dat <= wr_data;
      end
    end
  end

  // R1: reset image
  a_r1_reset_image: assert property (@(posedge clk)
    !rst_n |=> (regs_flat == RST_IMG) && !sda_pull && !wr_valid);

  // R2: acknowledge starts only while SCL is low
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  // R5: write pulse lasts one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5: write pulse comes with acknowledge
  a_r5_pulse_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_pull);

  // R9: register copy one cycle after the pulse
  a_r9_reg_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> regs_flat[32'(l_idx)*8 +: 8] == l_dat);

  // R9: no change without a pulse
  a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(regs_flat));
endmodule

bind i2c_regmap_slave i2cr_checker #(.IDX_W(IDX_W), .MUTE_BIT(MUTE_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_pull  (sda_pull),
  .wr_valid  (wr_valid),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .regs_flat (regs_flat)
);

// File: tb/sim_i2c_regmap_slave.sv
module sim_i2c_regmap_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull, wr_valid;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic [63:0] regs_flat;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mdl [8];
  int n_stb = 0;
  logic [2:0] log_idx [32];
  logic [7:0] log_dat [32];
  bit prev_v = 0;
  bit pend_v = 0;
  logic [2:0] pend_i;
  logic [7:0] pend_d;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_regmap_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Write-pulse monitor: R5 pulse width, R9 register copy one cycle later
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_v)
        chk(regs_flat[32'(pend_i)*8 +: 8] == pend_d, "R9 reg loaded after pulse",
            64'(regs_flat[32'(pend_i)*8 +: 8]), 64'(pend_d));
      if (wr_valid && prev_v)
        chk(0, "R5 pulse longer than one cycle", 1, 0);
      pend_v = wr_valid;
      if (wr_valid) begin
        pend_i = wr_idx;
        pend_d = wr_data;
        if (n_stb < 32) begin
          log_idx[n_stb] = wr_idx;
          log_dat[n_stb] = wr_data;
        end
        n_stb++;
      end
      prev_v = wr_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (all requirements) act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(1);
    scl = 1'b1;   wq(1);
    sda_m = 1'b0; wq(1);
    scl = 1'b0;   wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1);
    scl = 1'b1;   wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl = 1'b1;   wq(2);
      scl = 1'b0;   wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl = 1'b1;   wq(1);
    acked = !sda_line;
    wq(1);
    scl = 1'b0;   wq(1);
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++)
      chk(regs_flat[r*8 +: 8] == mdl[r], req, 64'(regs_flat[r*8 +: 8]), 64'(mdl[r]));
  endtask

  initial begin
    bit a;
    for (int r = 0; r < 8; r++) mdl[r] = 8'h00;
    mdl[7] = 8'h08;
    repeat (5) @(negedge clk);
    // R1: values during reset
    check_regs("R1 reset value");
    chk(!sda_pull && !wr_valid, "R1 outputs idle in reset", {sda_pull, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_regs("R1 value after release");

    // R2 R4 R5 R6: burst of nine bytes from each start subaddress (wraps)
    for (int s = 0; s < 8; s++) begin
      n_stb = 0;
      bus_start();
      send_byte(8'h80, a); chk(a, "R2 address ack", a, 1);
      send_byte(8'(s), a); chk(a, "R4 subaddress ack", a, 1);
      for (int k = 0; k < 9; k++) begin
        send_byte(pat(s, k), a); chk(a, "R5 data ack", a, 1);
        mdl[(s + k) % 8] = pat(s, k);
      end
      bus_stop();
      wq(1);
      chk(n_stb == 9, "R5 pulse count", n_stb, 9);
      for (int k = 0; k < 9; k++) begin
        chk(log_idx[k] == 3'((s + k) % 8), "R6 index increment and wrap", log_idx[k], (s + k) % 8);
        chk(log_dat[k] == pat(s, k), "R5 pulse data", log_dat[k], pat(s, k));
      end
      check_regs("R9 register contents");
    end

    // R4: upper subaddress bits ignored
    n_stb = 0;
    bus_start();
    send_byte(8'h80, a);
    send_byte(8'hF5, a); chk(a, "R4 subaddress with high bits ack", a, 1);
    send_byte(8'h3C, a);
    bus_stop(); wq(1);
    mdl[5] = 8'h3C;
    chk(n_stb == 1 && log_idx[0] == 3'd5, "R4 high bits ignored", log_idx[0], 5);
    check_regs("R4 register contents");

    // R3: wrong address, then bytes ignored
    n_stb = 0;
    bus_start();
    send_byte(8'h82, a); chk(!a, "R3 wrong address nack", a, 0);
    send_byte(8'h01, a); chk(!a, "R3 later byte nack", a, 0);
    send_byte(8'hAA, a); chk(!a, "R3 later byte nack", a, 0);
    bus_stop(); wq(1);
    chk(n_stb == 0, "R3 no write", n_stb, 0);
    check_regs("R3 registers unchanged");

    // R3: read bit set
    bus_start();
    send_byte(8'h81, a); chk(!a, "R3 read address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R3 byte after read nack", a, 0);
    bus_stop(); wq(1);
    chk(n_stb == 0, "R3 no write after read", n_stb, 0);

    // R7: repeated START returns to address reception
    n_stb = 0;
    bus_start();
    send_byte(8'h80, a);
    send_byte(8'h02, a);
    send_byte(8'h5A, a);
    bus_start();
    send_byte(8'h80, a); chk(a, "R7 address after repeated start", a, 1);
    send_byte(8'h06, a); chk(a, "R7 subaddress after repeated start", a, 1);
    send_byte(8'hC3, a);
    bus_stop(); wq(1);
    mdl[2] = 8'h5A; mdl[6] = 8'hC3;
    chk(n_stb == 2, "R7 pulse count", n_stb, 2);
    chk(log_idx[0] == 3'd2 && log_dat[0] == 8'h5A, "R7 first write", {log_idx[0], log_dat[0]}, {3'd2, 8'h5A});
    chk(log_idx[1] == 3'd6 && log_dat[1] == 8'hC3, "R7 second write", {log_idx[1], log_dat[1]}, {3'd6, 8'hC3});
    check_regs("R7 register contents");

    // R8: after STOP, bytes without START are ignored
    n_stb = 0;
    send_byte(8'h80, a); chk(!a, "R8 no ack without start", a, 0);
    send_byte(8'h01, a); chk(!a, "R8 no ack without start", a, 0);
    send_byte(8'h77, a); chk(!a, "R8 no ack without start", a, 0);
    wq(1);
    chk(n_stb == 0, "R8 no write without start", n_stb, 0);
    check_regs("R8 registers unchanged");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule